// File: doc/BRIEF.md
# Triangular Loop-Nest Scanner with Hazard Bubbles

This block turns a two-level triangular loop nest into one stream of index pairs (i, j), one pair per clock cycle. The outer index runs over 0 ≤ i < N and the inner index over 0 ≤ j < N−i, in lexicographic order. Each real index pair drives a four-stage read-modify-write pipeline that updates an on-chip vector: Y[j] becomes A[i] when i = 0 and A[i] + Y[j]·B[j] otherwise, kept to the data width. A multiplier takes the place of a divider in the update.

Row i+1 reads every Y[j] that row i wrote. A short row would therefore let the next row read a value before the write from the row above has left the pipeline. The scanner avoids this by extending rows: after the real iterations of a short row it keeps stepping j while it_valid stays low. These bubble cycles travel down the pipeline and do not write. Two padding rules can be selected at start. The compact rule pads a short row up to the pipeline latency. The plain rule appends latency−1 bubbles to every short row. Both rules give the same final Y.

The vectors A and B are loaded through a small write port. Y is read back through a registered read port. N is a runtime input and is sampled when a start is accepted. The done output rises only after the last real write has retired.

Top module: `coalesced_scan`

## Requirements
- R1: While reset is held and after it is released, it_valid and done are low.
- R2: Real iterations appear on it_i/it_j in lexicographic order, exactly once each, over 0 ≤ i < N and 0 ≤ j < N−i, one cycle per step. Within a row, j increments by one each cycle. After a row's last cycle the scanner moves to (i+1, 0). The scan ends after (N−1, 0).
- R3: With mode_cons = 0, every row i < N−1 with fewer than 4 real iterations takes exactly 4 cycles. For N = 5 the scan takes 18 cycles from first to last index.
- R4: With mode_cons = 1, every row i < N−1 with fewer than 4 real iterations takes its length plus 3 cycles. For N = 5 the scan takes 21 cycles.
- R5: For i ≥ 1, the index (i, j) is issued at least 4 cycles after (i−1, j), so every read of Y[j] sees the value written by the row above.
- R6: After a run, Y[j] for j < N equals the sequential evaluation of the loop nest using 16-bit wrap-around arithmetic. Both padding modes leave identical Y contents.
- R7: Bubble cycles have it_valid = 0 and do not write Y. Entries with j ≥ N keep their earlier contents.
- R8: done goes high 4 cycles after the cycle that shows the final index (N−1, 0). It stays high until the next accepted start, which clears it.
- R9: A start is ignored while the scanner is issuing or while any issued item is still inside the pipeline.
- R10: A start is ignored when n_in is 0 or greater than 16. In that case no index is issued and done keeps its value.
- R11: A load with ld_sel = 0 writes A[ld_addr] and a load with ld_sel = 1 writes B[ld_addr]. rd_data shows Y[rd_addr] one cycle after rd_addr is applied.
- R12: The first index (0, 0) with it_valid high appears in the cycle right after the clock edge that accepts start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a scan |
| mode_cons | input | 1 | Padding rule: 0 compact, 1 plain |
| n_in | input | 5 | Problem size N, valid range 1 to 16 |
| ld_we | input | 1 | Write strobe for the A/B load port |
| ld_sel | input | 1 | Load target: 0 selects A, 1 selects B |
| ld_addr | input | 4 | Load address |
| ld_data | input | 16 | Load data |
| rd_addr | input | 4 | Y read-back address |
| rd_data | output | 16 | Y read-back data, registered |
| it_i | output | 4 | Current outer index |
| it_j | output | 5 | Current inner index; can exceed the row length on bubbles |
| it_valid | output | 1 | High for a real iteration, low for a bubble or when idle |
| done | output | 1 | Last real write has retired |

## Verification
The hardest case to reach from the ports is a start request that arrives after the scanner has stopped issuing but while the final items are still moving through the pipeline. In that window a control that checked only the scanner would accept the request. The bench computes the offset of the last index from the row lengths. It then pulses start exactly two cycles after that offset, so the request lands while the tail item sits in the middle stage. The scoreboard rejects any extra index, and a shift in the done cycle is also caught. A second early pulse during issue, with a different N and the other mode, covers the in-flight case.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // cycles from the Y read in stage 1 to the Y write in stage 4
  localparam int CS_LAT = 4;

  // last inner index visited in row i (bubbles included)
  function automatic int row_last_j(input int n, input int i, input logic cons);
    int len;
    len = n - i;
    if (i < n - 1 && len < CS_LAT)
      return cons ? (len - 1 + CS_LAT - 1) : (CS_LAT - 1);
    return len - 1;
  endfunction
endpackage

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_pkg::*;
#(
  parameter int NMAX = 16,
  parameter int IW   = 4,
  parameter int JW   = 5,
  parameter int NW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_cons,
  input  logic [NW-1:0] n_in,
  input  logic          pipe_busy,
  input  logic          retire,
  output logic [IW-1:0] it_i,
  output logic [JW-1:0] it_j,
  output logic          it_valid,
  output logic          it_last,
  output logic          done
);
  logic          run_q;
  logic          cons_q;
  logic [NW-1:0] n_q;
  logic          accept;
  logic          end_scan;
  logic          nxt_v;
  int            n_v, i_v, j_v, lim, nxt_i, nxt_j;

  assign accept = start && !run_q && !pipe_busy &&
                  (n_in != '0) && (int'(n_in) <= NMAX);

  // guarded successor function over the padded triangular domain
  always_comb begin
    n_v = int'(n_q);
    i_v = int'(it_i);
    j_v = int'(it_j);
    lim = row_last_j(n_v, i_v, cons_q);
    if (j_v < lim) begin
      nxt_i = i_v;
      nxt_j = j_v + 1;
    end else begin
      nxt_i = i_v + 1;
      nxt_j = 0;
    end
    nxt_v    = nxt_j < (n_v - nxt_i);
    end_scan = (i_v == n_v - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      cons_q   <= 1'b0;
      n_q      <= '0;
      it_i     <= '0;
      it_j     <= '0;
      it_valid <= 1'b0;
      it_last  <= 1'b0;
    end else if (accept) begin
      run_q    <= 1'b1;
      cons_q   <= mode_cons;
      n_q      <= n_in;
      it_i     <= '0;
      it_j     <= '0;
      it_valid <= 1'b1;
      it_last  <= (n_in == NW'(1));
    end else if (run_q) begin
      if (end_scan) begin
        run_q    <= 1'b0;
        it_valid <= 1'b0;
        it_last  <= 1'b0;
      end else begin
        it_i     <= IW'(nxt_i);
        it_j     <= JW'(nxt_j);
        it_valid <= nxt_v;
        it_last  <= (nxt_i == n_v - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         done <= 1'b0;
    else if (accept) done <= 1'b0;
    else if (retire) done <= 1'b1;
  end

  // R2: consecutive scan positions strictly increase in (i, j) order
  assert_lex_order_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> ({it_i, it_j} > $past({it_i, it_j})));

  // R2: the outer index never leaves the domain while scanning
  assert_outer_range_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (int'(it_i) < int'(n_q)));

  // R8: done only rises once nothing is left in flight
  assert_done_drained_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!pipe_busy && !run_q && !it_valid));

  // R9: no start is taken while work remains
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (start && pipe_busy) |=> $stable(n_q));
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath #(
  parameter int NMAX = 16,
  parameter int DW   = 16,
  parameter int IW   = 4,
  parameter int JW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_v,
  input  logic [IW-1:0] s1_i,
  input  logic [JW-1:0] s1_j,
  input  logic          s1_last,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [IW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          retire
);
  logic [DW-1:0] mem_a [NMAX];
  logic [DW-1:0] mem_b [NMAX];
  logic [DW-1:0] mem_y [NMAX];

  // stage 2: operands read at the end of stage 1
  logic          s2_v, s2_last, s2_first;
  logic [JW-1:0] s2_j;
  logic [DW-1:0] s2_a, s2_b, s2_y;
  // stage 3: product
  logic          s3_v, s3_last, s3_first;
  logic [JW-1:0] s3_j;
  logic [DW-1:0] s3_a, s3_prod;
  // stage 4: sum, written back at the end of this stage
  logic          s4_v, s4_last;
  logic [JW-1:0] s4_j;
  logic [DW-1:0] s4_sum;

  always_ff @(posedge clk) begin
    if (ld_we && !ld_sel) mem_a[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_we && ld_sel) mem_b[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (s4_v) mem_y[s4_j[IW-1:0]] <= s4_sum;
  end

  always_ff @(posedge clk) begin
    s2_a    <= mem_a[s1_i];
    s2_b    <= mem_b[s1_j[IW-1:0]];
    s2_y    <= mem_y[s1_j[IW-1:0]];
    rd_data <= mem_y[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0;
      s2_last <= 1'b0; s3_last <= 1'b0; s4_last <= 1'b0;
    end else begin
      s2_v <= s1_v; s2_last <= s1_v && s1_last;
      s3_v <= s2_v; s3_last <= s2_last;
      s4_v <= s3_v; s4_last <= s3_last;
    end
  end

  always_ff @(posedge clk) begin
    s2_j     <= s1_j;
    s2_first <= (s1_i == '0);
    s3_j     <= s2_j;
    s3_first <= s2_first;
    s3_a     <= s2_a;
    s3_prod  <= DW'(s2_y * s2_b);
    s4_j     <= s3_j;
    s4_sum   <= s3_first ? s3_a : DW'(s3_a + s3_prod);
  end

  assign busy   = s2_v || s3_v || s4_v;
  assign retire = s4_v && s4_last;

  // R5: a Y read for i >= 1 never overlaps a pending write to the same entry
  assert_raw_distance_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_i != '0) |->
      !((s2_v && s2_j == s1_j) || (s3_v && s3_j == s1_j) || (s4_v && s4_j == s1_j)));

  // R7: a retiring item always carries a real in-range index
  assert_write_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    s4_v |-> (int'(s4_j) < NMAX));
endmodule

// File: rtl/coalesced_scan.sv
module coalesced_scan
  import cs_pkg::*;
#(
  parameter int NMAX = 16,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NMAX),
  localparam int JW  = $clog2(NMAX + CS_LAT),
  localparam int NW  = $clog2(NMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_cons,
  input  logic [NW-1:0] n_in,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [IW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [IW-1:0] it_i,
  output logic [JW-1:0] it_j,
  output logic          it_valid,
  output logic          done
);
  logic pipe_busy;
  logic retire;
  logic it_last;

  cs_sequencer #(.NMAX(NMAX), .IW(IW), .JW(JW), .NW(NW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode_cons(mode_cons), .n_in(n_in),
    .pipe_busy(pipe_busy), .retire(retire),
    .it_i(it_i), .it_j(it_j), .it_valid(it_valid), .it_last(it_last), .done(done)
  );

  cs_datapath #(.NMAX(NMAX), .DW(DW), .IW(IW), .JW(JW)) u_dp (
    .clk(clk), .rst(rst),
    .s1_v(it_valid), .s1_i(it_i), .s1_j(it_j), .s1_last(it_last),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(pipe_busy), .retire(retire)
  );
endmodule

// File: tb/tb_coalesced_scan.sv
`timescale 1ns/1ps
module tb_coalesced_scan;
  localparam int NMAX = 16;
  localparam int DW   = 16;
  localparam int IW   = 4;
  localparam int JW   = 5;
  localparam int NW   = 5;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_cons = 1'b0;
  logic [NW-1:0] n_in = '0;
  logic ld_we = 1'b0, ld_sel = 1'b0;
  logic [IW-1:0] ld_addr = '0, rd_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] rd_data;
  logic [IW-1:0] it_i;
  logic [JW-1:0] it_j;
  logic it_valid, done;

  coalesced_scan #(.NMAX(NMAX), .DW(DW)) dut (
    .clk(clk), .rst(rst), .start(start), .mode_cons(mode_cons), .n_in(n_in),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .it_i(it_i), .it_j(it_j), .it_valid(it_valid), .done(done)
  );

  always #10 clk = ~clk;   // 50 MHz

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int i; int j; int off; } item_t;
  item_t exq[$];
  int t0 = 0, exp_done_off = 0, last_seen_off = 0;
  string ord_tag = "R12";
  logic done_prev = 1'b0;
  int last_abs[NMAX];
  logic [DW-1:0] ref_a[NMAX], ref_b[NMAX], ref_y[NMAX], snap[NMAX];
  bit ref_known[NMAX];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every real iteration
  always @(negedge clk) begin
    if (!rst) begin
      if (it_valid) begin
        if (exq.size() == 0) chk(1'b0, "R9 unexpected index", int'(it_i)*100 + int'(it_j), -1);
        else begin
          item_t e;
          e = exq.pop_front();
          chk(int'(it_i) == e.i && int'(it_j) == e.j, "R2 index",
              int'(it_i)*100 + int'(it_j), e.i*100 + e.j);
          chk(cyc - t0 == e.off, ord_tag, cyc - t0, e.off);
          if (e.i > 0)
            chk(cyc - last_abs[e.j] >= 4, "R5 read-after-write distance", cyc - last_abs[e.j], 4);
          last_abs[e.j] = cyc;
          last_seen_off = cyc - t0;
        end
      end
      if (done && !done_prev) chk(cyc - t0 == exp_done_off, "R8 done cycle", cyc - t0, exp_done_off);
      done_prev = done;
    end
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic load(input bit sel, input int addr, input int val);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = IW'(addr); ld_data = DW'(val);
    if (sel) ref_b[addr] = DW'(val); else ref_a[addr] = DW'(val);
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic read_y(input int j, output logic [DW-1:0] v);
    @(negedge clk);
    rd_addr = IW'(j);
    @(negedge clk);
    v = rd_data;
  endtask

  // poke: 0 none, 1 during issue, 2 while the pipeline drains
  task automatic run(input int n, input bit cons, input int poke);
    int off, len, rows;
    off = 0;
    for (int i = 0; i < n; i++) begin
      len  = n - i;
      rows = (i < n - 1 && len < 4) ? (cons ? len + 3 : 4) : len;
      for (int j = 0; j < rows; j++) begin
        if (j < len) exq.push_back('{i, j, off});
        off++;
      end
    end
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - i; j++) begin
        ref_y[j] = (i == 0) ? ref_a[i] : DW'(ref_a[i] + ref_y[j] * ref_b[j]);
        ref_known[j] = 1'b1;
      end
    exp_done_off = off - 1 + 4;
    ord_tag = cons ? "R4 R12 issue cycle" : "R3 R12 issue cycle";
    @(negedge clk);
    n_in = NW'(n); mode_cons = cons; start = 1'b1; t0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    if (poke != 0) begin
      repeat ((poke == 1) ? 2 : off + 1) @(negedge clk);
      n_in = NW'(3); mode_cons = ~cons; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    begin
      int k;
      k = 0;
      while (!done && k < 1000) begin @(negedge clk); k++; end
    end
    chk(done, "R8 done reached", int'(done), 1);
    chk(exq.size() == 0, "R2 all iterations issued", exq.size(), 0);
    exq.delete();
    if (n == 5) begin
      if (cons) chk(last_seen_off + 1 == 21, "R4 scan length", last_seen_off + 1, 21);
      else      chk(last_seen_off + 1 == 18, "R3 scan length", last_seen_off + 1, 18);
    end
    for (int j = 0; j < NMAX; j++) begin
      logic [DW-1:0] v;
      if (ref_known[j]) begin
        read_y(j, v);
        chk(v == ref_y[j], "R6 R7 R11 Y contents", int'(v), int'(ref_y[j]));
      end
    end
  endtask

  task automatic bad_start(input int n);
    @(negedge clk);
    n_in = NW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!it_valid && done, "R10 bad size ignored", int'(it_valid)*10 + int'(done), 1);
    end
  endtask

  initial begin
    for (int j = 0; j < NMAX; j++) begin ref_known[j] = 1'b0; last_abs[j] = 0; end
    repeat (3) @(negedge clk);
    chk(!it_valid && !done, "R1 in reset", int'(it_valid)*10 + int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!it_valid && !done, "R1 after reset", int'(it_valid)*10 + int'(done), 0);
    for (int k = 0; k < NMAX; k++) begin
      load(1'b0, k, 3*k + 1);
      load(1'b1, k, (k % 3) + 2);
    end
    run(5, 1'b0, 0);
    for (int j = 0; j < 5; j++) read_y(j, snap[j]);
    run(5, 1'b1, 0);
    for (int j = 0; j < 5; j++) begin
      logic [DW-1:0] v;
      read_y(j, v);
      chk(v == snap[j], "R6 modes agree", int'(v), int'(snap[j]));
    end
    run(1, 1'b0, 0);
    run(2, 1'b0, 0);
    run(3, 1'b1, 0);
    run(4, 1'b0, 0);
    run(4, 1'b1, 0);
    run(16, 1'b0, 0);
    run(16, 1'b1, 0);
    run(7, 1'b1, 1);
    run(6, 1'b0, 2);
    bad_start(0);
    bad_start(17);
    load(1'b1, 2, 9);
    run(5, 1'b0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule